// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a blocking data cache placed between a processor load/store port and a word-wide port to a lower-level block memory. Each line has one tag, a valid flag, a modified flag and a block of data words. A 32-bit byte address is split into tag, line index and byte offset. A lookup takes a single cycle. A load that hits returns the addressed word in the same cycle. A store that hits writes only the cached copy and marks the line modified.

On a miss the cache raises a stall towards the processor at once. If the victim line is modified, its words go back to memory first. The new block is then fetched one word per handshake, its tag is installed and the line is marked valid. The held access then completes as a hit. This replay is not counted again. Two saturating counters report how many accesses hit on first lookup and how many missed.

Top module: `dm_wb_cache`

## Requirements
- R1: With the default parameters, address bits [3:0] are the byte offset, bits [8:4] the line index (block address modulo 32) and bits [31:9] the tag. Bits [3:2] pick the word within the line, and bits [1:0] do not affect the result.
- R2: An access hits only when the indexed line is valid and its stored tag equals the address tag. A hit completes with the stall low in the cycle the request is presented, and a load returns the current value of the word.
- R3: A store hit updates only the cached word and marks the line modified. No memory transfer takes place.
- R4: A miss drives the stall high in the cycle the request is presented. The stall stays high until the line has been refilled and the held access completes.
- R5: When the victim is valid and modified, its four words are written to memory before any fill read. The writes go word 0 first, to byte address {stored tag, index, word, 2'b00}. A clean or invalid victim causes no memory write.
- R6: A fill reads four words, word 0 first, from byte address {address tag, index, word, 2'b00}. It then installs the tag, sets the valid flag and clears the modified flag, after which the stalled access completes.
- R7: A store miss allocates the line. The block is fetched, the store data is merged into it and the line becomes modified. Memory is not written by the store itself.
- R8: Reset clears every valid and modified flag and both counters. The first access after reset misses and writes nothing back.
- R9: The memory request stays high, with address, direction and write data held, until the memory acknowledges. Each acknowledge moves exactly one word.
- R10: The hit counter counts accesses that hit on first lookup. The miss counter counts each miss once. Both stop at their all-ones value.
- R11: From reset, loads to byte addresses 1000, 1004, 1008, 2548, 2552 and 2556 give miss, hit, miss, miss, hit, hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held while stalled |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when request is high and stall low |
| cpu_stall | output | 1 | Processor must hold its request |
| mem_req | output | 1 | Memory word transfer request |
| mem_we | output | 1 | 1 = write-back word, 0 = fill read |
| mem_addr | output | 32 | Byte address of the word transferred |
| mem_wdata | output | 32 | Write-back word |
| mem_rdata | input | 32 | Fill word, sampled with the acknowledge |
| mem_ack | input | 1 | One word transferred this cycle |
| hit_count | output | CNT_W | Saturating first-lookup hit count |
| miss_count | output | CNT_W | Saturating miss count |

## Verification
The assertions assume that the processor keeps the request, direction, address and store data unchanged while the stall is high. They also assume that the memory raises its acknowledge only while a request is outstanding, and for one cycle per word. The bench drives accesses from a task that holds every processor input until the stall drops, and then removes the request for at least one cycle. Its memory responder acknowledges only pending requests and leaves some cycles without an acknowledge, so that the hold rules are exercised. Each transfer is checked against a queue of the write-backs and fills the model predicts.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVICT = 2'd1,
    ST_FILL  = 2'd2
  } fsm_t;
endpackage

// File: rtl/dmc_sat_counter.sv
module dmc_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                   count <= '0;
    else if (inc && count != TOP) count <= count + 1'b1;
  end

  assert_sat_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (count == TOP) |=> (count == TOP));
  assert_sat_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && count != TOP) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/dmc_store.sv
module dmc_store #(
  parameter int LINES  = 32,
  parameter int WPL    = 4,
  parameter int WORD_W = 32,
  parameter int TAG_W  = 23,
  localparam int IDX_W  = $clog2(LINES),
  localparam int WSEL_W = $clog2(WPL)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [IDX_W-1:0]      idx,
  output logic [TAG_W-1:0]      rd_tag,
  output logic                  rd_valid,
  output logic                  rd_dirty,
  output logic [WPL*WORD_W-1:0] rd_line,
  input  logic                  wr_en,
  input  logic [WSEL_W-1:0]     wr_sel,
  input  logic [WORD_W-1:0]     wr_data,
  input  logic                  meta_en,
  input  logic [TAG_W-1:0]      meta_tag,
  input  logic                  dirty_en
);
  logic [WORD_W-1:0] data_q [LINES][WPL];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINES-1:0]  valid_q;
  logic [LINES-1:0]  dirty_q;

  always_ff @(posedge clk) begin
    if (wr_en) data_q[idx][wr_sel] <= wr_data;
    if (meta_en) tag_q[idx] <= meta_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (meta_en) begin
      valid_q[idx] <= 1'b1;
      dirty_q[idx] <= 1'b0;
    end else if (dirty_en) begin
      dirty_q[idx] <= 1'b1;
    end
  end

  assign rd_tag   = tag_q[idx];
  assign rd_valid = valid_q[idx];
  assign rd_dirty = dirty_q[idx];

  for (genvar w = 0; w < WPL; w++) begin : g_word
    assign rd_line[w*WORD_W +: WORD_W] = data_q[idx][w];
  end

  assert_store_marks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_en && !meta_en |=> dirty_q[$past(idx)]);
  assert_fill_meta_R6: assert property (@(posedge clk) disable iff (!rst_n)
    meta_en |=> valid_q[$past(idx)] && !dirty_q[$past(idx)]
                && tag_q[$past(idx)] == $past(meta_tag));
endmodule

// File: rtl/dmc_fsm.sv
module dmc_fsm
  import dmc_pkg::*;
#(
  parameter int WSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic              hit,
  input  logic              victim_dirty,
  input  logic              mem_ack,
  output fsm_t              state,
  output logic [WSEL_W-1:0] beat,
  output logic              stall,
  output logic              mem_req,
  output logic              mem_we,
  output logic              fill_we,
  output logic              meta_en,
  output logic              dirty_en,
  output logic              done,
  output logic              hit_evt,
  output logic              miss_evt
);
  localparam logic [WSEL_W-1:0] LAST = '1;

  logic replay_q;
  logic look;
  logic last;

  assign look     = (state == ST_IDLE) && req;
  assign last     = (beat == LAST);
  assign done     = look && hit;
  assign miss_evt = look && !hit;
  assign hit_evt  = done && !replay_q;
  assign stall    = (state != ST_IDLE) || (req && !hit);
  assign mem_req  = (state != ST_IDLE);
  assign mem_we   = (state == ST_EVICT);
  assign fill_we  = (state == ST_FILL) && mem_ack;
  assign meta_en  = fill_we && last;
  assign dirty_en = done && we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      beat     <= '0;
      replay_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (miss_evt) begin
            state <= victim_dirty ? ST_EVICT : ST_FILL;
            beat  <= '0;
          end else if (done) begin
            replay_q <= 1'b0;
          end
        end
        ST_EVICT: begin
          if (mem_ack) begin
            beat <= beat + 1'b1;
            if (last) state <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_ack) begin
            beat <= beat + 1'b1;
            if (last) begin
              state    <= ST_IDLE;
              replay_q <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_miss_leaves_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && req && !hit) |=> (state != ST_IDLE));
  assert_dirty_evicts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && req && !hit && victim_dirty) |=> (state == ST_EVICT));
  assert_clean_fills_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && req && !hit && !victim_dirty) |=> (state == ST_FILL));
  assert_fill_returns_R6: assert property (@(posedge clk) disable iff (!rst_n)
    meta_en |=> (state == ST_IDLE));
endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache
  import dmc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINES      = 32,
  parameter int LINE_BYTES = 16,
  parameter int WORD_BYTES = 4,
  parameter int CNT_W      = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cpu_req,
  input  logic                  cpu_we,
  input  logic [ADDR_W-1:0]     cpu_addr,
  input  logic [8*WORD_BYTES-1:0] cpu_wdata,
  output logic [8*WORD_BYTES-1:0] cpu_rdata,
  output logic                  cpu_stall,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [8*WORD_BYTES-1:0] mem_wdata,
  input  logic [8*WORD_BYTES-1:0] mem_rdata,
  input  logic                  mem_ack,
  output logic [CNT_W-1:0]      hit_count,
  output logic [CNT_W-1:0]      miss_count
);
  localparam int WORD_W = 8 * WORD_BYTES;
  localparam int WPL    = LINE_BYTES / WORD_BYTES;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int BSEL_W = $clog2(WORD_BYTES);
  localparam int WSEL_W = $clog2(WPL);

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [WSEL_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return a[BSEL_W +: WSEL_W];
  endfunction

  function automatic logic [ADDR_W-1:0] word_addr(input logic [TAG_W-1:0] t,
                                                  input logic [IDX_W-1:0] i,
                                                  input logic [WSEL_W-1:0] w);
    return {t, i, w, {BSEL_W{1'b0}}};
  endfunction

  // decoded request
  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [WSEL_W-1:0] req_word;
  logic              unused_byte_sel;

  assign req_tag         = tag_of(cpu_addr);
  assign req_idx         = idx_of(cpu_addr);
  assign req_word        = word_of(cpu_addr);
  assign unused_byte_sel = ^cpu_addr[BSEL_W-1:0];

  // stored line
  logic [TAG_W-1:0]      st_tag;
  logic                  st_valid;
  logic                  st_dirty;
  logic [WPL*WORD_W-1:0] st_line;
  logic [WORD_W-1:0]     line_w [WPL];

  for (genvar w = 0; w < WPL; w++) begin : g_unpack
    assign line_w[w] = st_line[w*WORD_W +: WORD_W];
  end

  // named internal events
  fsm_t              state;
  logic [WSEL_W-1:0] beat;
  logic              hit_w;
  logic              victim_dirty_w;
  logic              fill_we_w;
  logic              meta_en_w;
  logic              dirty_en_w;
  logic              done_w;
  logic              hit_evt_w;
  logic              miss_evt_w;
  logic              wr_en_w;
  logic [WSEL_W-1:0] wr_sel_w;
  logic [WORD_W-1:0] wr_data_w;

  assign hit_w          = st_valid && (st_tag == req_tag);
  assign victim_dirty_w = st_valid && st_dirty;
  assign wr_en_w        = fill_we_w || dirty_en_w;
  assign wr_sel_w       = fill_we_w ? beat : req_word;
  assign wr_data_w      = fill_we_w ? mem_rdata : cpu_wdata;

  dmc_store #(
    .LINES (LINES),
    .WPL   (WPL),
    .WORD_W(WORD_W),
    .TAG_W (TAG_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx     (req_idx),
    .rd_tag  (st_tag),
    .rd_valid(st_valid),
    .rd_dirty(st_dirty),
    .rd_line (st_line),
    .wr_en   (wr_en_w),
    .wr_sel  (wr_sel_w),
    .wr_data (wr_data_w),
    .meta_en (meta_en_w),
    .meta_tag(req_tag),
    .dirty_en(dirty_en_w)
  );

  dmc_fsm #(
    .WSEL_W(WSEL_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (cpu_req),
    .we          (cpu_we),
    .hit         (hit_w),
    .victim_dirty(victim_dirty_w),
    .mem_ack     (mem_ack),
    .state       (state),
    .beat        (beat),
    .stall       (cpu_stall),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .fill_we     (fill_we_w),
    .meta_en     (meta_en_w),
    .dirty_en    (dirty_en_w),
    .done        (done_w),
    .hit_evt     (hit_evt_w),
    .miss_evt    (miss_evt_w)
  );

  dmc_sat_counter #(.W(CNT_W)) u_hits (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (hit_evt_w),
    .count(hit_count)
  );

  dmc_sat_counter #(.W(CNT_W)) u_misses (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (miss_evt_w),
    .count(miss_count)
  );

  assign cpu_rdata = line_w[req_word];
  assign mem_wdata = line_w[beat];
  assign mem_addr  = mem_we ? word_addr(st_tag, req_idx, beat)
                            : word_addr(req_tag, req_idx, beat);

  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                              && $stable(mem_wdata));
  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_stall) |=> cpu_req && $stable(cpu_addr) && $stable(cpu_we));
  assert_done_not_stalled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_w |-> !cpu_stall && !mem_req);
  assert_single_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_evt_w && miss_evt_w));
endmodule

// File: tb/dm_wb_cache_bench.sv
module dm_wb_cache_bench;
  localparam int CLK_NS = 10;
  localparam int CW     = 4;
  localparam int CMAX   = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req = 1'b0;
  logic          cpu_we = 1'b0;
  logic [31:0]   cpu_addr = '0;
  logic [31:0]   cpu_wdata = '0;
  logic [31:0]   cpu_rdata;
  logic          cpu_stall;
  logic          mem_req;
  logic          mem_we;
  logic [31:0]   mem_addr;
  logic [31:0]   mem_wdata;
  logic [31:0]   mem_rdata = '0;
  logic          mem_ack = 1'b0;
  logic [CW-1:0] hit_count;
  logic [CW-1:0] miss_count;

  dm_wb_cache #(.CNT_W(CW)) u_dm_wb_cache (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // reference memories, keyed by word address
  logic [31:0] gold [int unsigned];
  logic [31:0] bmem [int unsigned];

  function automatic logic [31:0] seed_val(input int unsigned wa);
    return (wa * 32'h9E37) ^ 32'h5A5A_0000;
  endfunction
  function automatic logic [31:0] gold_rd(input int unsigned wa);
    return gold.exists(wa) ? gold[wa] : seed_val(wa);
  endfunction
  function automatic logic [31:0] bmem_rd(input int unsigned wa);
    return bmem.exists(wa) ? bmem[wa] : seed_val(wa);
  endfunction

  // reference cache state
  int unsigned mtag  [32];
  bit          mval  [32];
  bit          mdirty[32];
  int          exp_hit  = 0;
  int          exp_miss = 0;
  bit          last_miss;

  typedef struct { bit we; logic [31:0] addr; } xfer_t;
  xfer_t xq[$];

  // memory responder
  int          cyc = 0;
  bit          holding = 1'b0;
  logic [31:0] held_addr = '0;

  always @(negedge clk) begin
    cyc++;
    if (holding) chk(mem_addr == held_addr, "R9", "address moved while waiting", mem_addr, held_addr);
    holding = 1'b0;
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (rst_n && mem_req) begin
      if (cyc % 3 == 1) begin
        holding   = 1'b1;
        held_addr = mem_addr;
      end else if (xq.size() == 0) begin
        chk(1'b0, "R3", "unexpected memory transfer", mem_addr, 32'h0);
        mem_ack = 1'b1;
      end else begin
        xfer_t x;
        x = xq.pop_front();
        chk(mem_we == x.we, x.we ? "R5" : "R6", "transfer direction", 32'(mem_we), 32'(x.we));
        chk(mem_addr == x.addr, x.we ? "R5" : "R6", "transfer address", mem_addr, x.addr);
        if (mem_we) begin
          chk(mem_wdata == gold_rd(mem_addr >> 2), "R5", "write-back data",
              mem_wdata, gold_rd(mem_addr >> 2));
          bmem[mem_addr >> 2] = mem_wdata;
        end else begin
          mem_rdata = bmem_rd(mem_addr >> 2);
        end
        mem_ack = 1'b1;
      end
    end
  end

  // counters compared every clock
  always @(negedge clk) begin
    if (rst_n) begin
      chk(hit_count == CW'(exp_hit), "R10", "hit counter", 32'(hit_count), exp_hit);
      chk(miss_count == CW'(exp_miss), "R10", "miss counter", 32'(miss_count), exp_miss);
    end
  end

  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] d,
                        input string rq);
    int unsigned idx, t, wa;
    bit mh;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    #1;
    idx = (a >> 4) % 32;
    t   = a >> 9;
    wa  = a >> 2;
    mh  = mval[idx] && (mtag[idx] == t);
    last_miss = !mh;
    chk(cpu_stall == !mh, mh ? rq : "R4", "stall on first look", 32'(cpu_stall), 32'(!mh));
    if (!mh) begin
      if (mval[idx] && mdirty[idx])
        for (int w = 0; w < 4; w++) xq.push_back('{1'b1, (mtag[idx] << 9) | (idx << 4) | (w << 2)});
      for (int w = 0; w < 4; w++) xq.push_back('{1'b0, (t << 9) | (idx << 4) | (w << 2)});
      mtag[idx] = t; mval[idx] = 1'b1; mdirty[idx] = 1'b0;
      @(posedge clk);
      if (exp_miss < CMAX) exp_miss++;
      forever begin
        @(negedge clk); #1;
        if (!cpu_stall) break;
      end
      chk(xq.size() == 0, "R6", "transfers left after refill", xq.size(), 0);
    end
    if (!we) chk(cpu_rdata == gold_rd(wa), rq, "load data", cpu_rdata, gold_rd(wa));
    else begin gold[wa] = d; mdirty[idx] = 1'b1; end
    @(posedge clk);
    if (mh && exp_hit < CMAX) exp_hit++;
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  // watchdog
  int wd = 0;
  always @(negedge clk) begin
    wd++;
    if (wd > 100000) begin
      chk(1'b0, "R4", "watchdog expired", wd, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  int          ex_addr [6] = '{1000, 1004, 1008, 2548, 2552, 2556};
  bit          ex_miss [6] = '{1, 0, 1, 1, 0, 0};
  logic [31:0] rs = 32'h1D2C_3B4A;

  initial begin
    for (int i = 0; i < 32; i++) begin mval[i] = 0; mdirty[i] = 0; mtag[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk); #1;
    chk(cpu_stall == 1'b0, "R8", "stall after reset", 32'(cpu_stall), 0);
    chk(mem_req == 1'b0, "R8", "memory request after reset", 32'(mem_req), 0);
    chk(hit_count == 0 && miss_count == 0, "R8", "counters after reset",
        {hit_count, miss_count}, 0);

    access(1'b0, 32'h0, 32'h0, "R8");
    chk(last_miss, "R8", "first access after reset", 32'(last_miss), 1);

    for (int i = 0; i < 6; i++) begin
      access(1'b0, ex_addr[i], 32'h0, "R11");
      chk(last_miss == ex_miss[i], "R11", "example hit/miss", 32'(last_miss), 32'(ex_miss[i]));
    end

    access(1'b0, 32'd1001, 32'h0, "R1");
    chk(!last_miss, "R1", "byte bits ignored", 32'(last_miss), 0);

    access(1'b1, 32'd1004, 32'hCAFE_0001, "R3");
    chk(!last_miss, "R3", "store hit", 32'(last_miss), 0);
    chk(bmem_rd(1004 >> 2) == seed_val(1004 >> 2), "R3", "memory untouched by store hit",
        bmem_rd(1004 >> 2), seed_val(1004 >> 2));
    access(1'b0, 32'd1004, 32'h0, "R3");

    access(1'b0, 32'd1512, 32'h0, "R5");
    chk(bmem_rd(1004 >> 2) == 32'hCAFE_0001, "R5", "dirty word written back",
        bmem_rd(1004 >> 2), 32'hCAFE_0001);
    access(1'b0, 32'd1004, 32'h0, "R5");
    chk(last_miss, "R5", "evicted line misses", 32'(last_miss), 1);

    access(1'b1, 32'd4000, 32'h1234_ABCD, "R7");
    chk(last_miss, "R7", "store miss", 32'(last_miss), 1);
    chk(bmem_rd(4000 >> 2) == seed_val(4000 >> 2), "R7", "store not sent to memory",
        bmem_rd(4000 >> 2), seed_val(4000 >> 2));
    access(1'b0, 32'd4000, 32'h0, "R7");
    chk(!last_miss, "R7", "allocated line hits", 32'(last_miss), 0);
    access(1'b0, 32'd4004, 32'h0, "R6");

    for (int i = 0; i < 120; i++) begin
      rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
      access(rs[31], ((rs % 4) << 9) | (((rs >> 3) % 32) << 4) | (((rs >> 9) % 4) << 2) | (rs >> 20) % 4,
             rs ^ 32'hA5A5_5A5A, "R2");
    end

    for (int i = 0; i < 20; i++) access(1'b0, 32'd4000, 32'h0, "R2");
    @(negedge clk); #1;
    chk(hit_count == CW'(CMAX), "R10", "hit counter saturated", 32'(hit_count), CMAX);
    chk(miss_count == CW'(CMAX), "R10", "miss counter saturated", 32'(miss_count), CMAX);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule